// File: doc/BRIEF.md
# Clock synthesizer mode sequencer

This block sequences a clock synthesizer between two operating modes and produces the resulting output clock as a one-cycle enable pulse stream in the system clock domain. In bypass mode every output pulse is derived from the reference by an integer divide of N2+1. In lock mode a behavioural synthesizer produces events at M/(N+1) times the reference event rate, and a post-divider passes one event in M2+1. The analog loop is not modelled. Instead, a lock timer asserts the locked status a programmable number of reference events after software asks for lock.

Software drives the block through a small word-addressed register port. It writes a mode code to request bypass or lock. While the block sits in bypass it reprograms the feedback values, then requests lock and polls the locked flag. The post-divider may be rewritten while the block is running. The new ratio takes effect on the next output period boundary, so no runt period appears, and an acknowledge bit inverts at that moment. Whenever the output source changes, the output is held quiet for a fixed number of cycles.

Register map (32-bit words, `addr`): 0 mode code in bits [2:0]; 1 feedback, multiply M in bits [10:0] and divide N in bits [22:16]; 2 bypass divide N2 in bits [3:0]; 3 post-divide M2 in bits [4:0] with the acknowledge in bit 31; 4 lock time T in bits [15:0]; 5 status, bit 0 bypass and bit 1 locked. Other addresses read as zero.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the status word reads bypass=1 and locked=0. The mode field reads 0x4, the acknowledge reads 0, M reads 1, N reads 0, N2 reads 0, M2 reads 0 and T reads 16.
- R2: A write of mode code 0x7 while in bypass starts the lock timer. The timer counts cycles with `ref_en` high. With `ref_en` high on every cycle, locked reads 1 exactly T+1 cycles after the write edge and not earlier. With T=0 this is the next cycle.
- R3: Status bit 0 (bypass) and bit 1 (locked) are never both set and never both clear. While lock is pending, the status reads bypass.
- R4: In bypass, `clk_pulse` carries one pulse per N2+1 cycles with `ref_en` high.
- R5: In lock mode, synthesized events occur at M/(N+1) per `ref_en` event, with at most one per clock cycle. `clk_pulse` carries one pulse per M2+1 events.
- R6: A write of mode code 0x4 in any state makes the status read bypass=1 and locked=0 at the first sample after the write edge.
- R7: Writes to the feedback word are ignored unless the block is in bypass with no lock pending. A readback then still shows the previous values.
- R8: An M2 write while locked is applied at the next output pulse. The acknowledge inverts in the same cycle that `clk_pulse` is high, and either direction of inversion counts.
- R9: An M2 write while not locked is applied one cycle after the write edge, and the acknowledge inverts at that point.
- R10: A write of any mode code other than 0x4 or 0x7 leaves the mode and the status unchanged.
- R11: When the output source changes, `clk_pulse` stays low in the switching cycle and for the following 4 cycles (HOLD_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock event, one cycle per reference edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| clk_pulse | output | 1 | Registered output clock enable pulse |

## Verification
Status, mode and feedback readback change at the write edge, so the bench samples them at the negedge that follows. An M2 write while not locked shows its acknowledge one edge later. The locked flag is due T+1 edges after the lock write, and the bench samples at T and at T+1 to pin that exact edge. After a source change the bench samples `clk_pulse` on each of the next five negedges. Output rates are judged by counting pulses over windows that are whole multiples of the steady-state period, after a settle delay, so the phase of the dividers does not matter. For on-the-fly M2 changes the bench polls the acknowledge bit every cycle and, in the cycle where it flips, requires `clk_pulse` to be high.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [1:0] {
      ST_BYP     = 2'd0,
      ST_LOCKING = 2'd1,
      ST_LOCKED  = 2'd2
   } seq_state_t;

   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;

   localparam logic [2:0] CODE_BYP  = 3'h4;
   localparam logic [2:0] CODE_LOCK = 3'h7;

   localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
   localparam logic [ADDR_W-1:0] A_FB     = 3'd1;
   localparam logic [ADDR_W-1:0] A_BYPDIV = 3'd2;
   localparam logic [ADDR_W-1:0] A_POST   = 3'd3;
   localparam logic [ADDR_W-1:0] A_LTIME  = 3'd4;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

   localparam int FB_DIV_LSB = 16;
   localparam int ACK_BIT    = 31;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ev,
   input  logic [W-1:0] ratio,
   output logic         tick
);

   logic [W-1:0] cnt_q;

   // ratio may drop below the running count; >= keeps it from stalling
   assign tick = ev && (cnt_q >= ratio);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (ev) begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pll_seq_synth.sv
module pll_seq_synth #(
   parameter int MULT_W = 11,
   parameter int DIV_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ref_en,
   input  logic [MULT_W-1:0] mult,
   input  logic [DIV_W-1:0]  div,
   output logic              ev
);

   localparam int ACC_W = ((MULT_W > DIV_W) ? MULT_W : DIV_W) + 2;

   logic [ACC_W-1:0] acc_q, sum, den, rem, acc_d;

   always_comb begin
      sum = acc_q + (ref_en ? ACC_W'(mult) : '0);
      den = ACC_W'(div) + 1'b1;
      ev  = (sum >= den);
      rem = ev ? (sum - den) : sum;
      // rate is capped at one event per cycle; keep the residue bounded
      acc_d = (rem >= den) ? (den - 1'b1) : rem;
   end

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_d;
   end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int LT_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ref_en,
   input  logic            mode_wr,
   input  logic [2:0]      mode_code,
   input  logic [LT_W-1:0] lock_time,
   output seq_state_t      state,
   output logic            src_switch
);

   seq_state_t      st_q, st_d;
   logic [LT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_BYP: begin
            if (mode_wr && mode_code == CODE_LOCK) begin
               st_d  = ST_LOCKING;
               cnt_d = '0;
            end
         end
         ST_LOCKING: begin
            if (mode_wr && mode_code == CODE_BYP)  st_d  = ST_BYP;
            else if (cnt_q >= lock_time)           st_d  = ST_LOCKED;
            else if (ref_en)                       cnt_d = cnt_q + 1'b1;
         end
         ST_LOCKED: begin
            if (mode_wr && mode_code == CODE_BYP)  st_d  = ST_BYP;
         end
         default: st_d = ST_BYP;
      endcase
   end

   assign src_switch = (st_d == ST_LOCKED) != (st_q == ST_LOCKED);
   assign state      = st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_BYP;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   a_r1_reset_bypass: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> st_q == ST_BYP);

   a_r2_lock_after_timer: assert property (@(posedge clk) disable iff (rst)
      $rose(st_q == ST_LOCKED) |-> $past(cnt_q) >= $past(lock_time));

   a_r6_bypass_next: assert property (@(posedge clk) disable iff (rst)
      (mode_wr && mode_code == CODE_BYP) |=> st_q == ST_BYP);

   a_r10_bad_code_kept: assert property (@(posedge clk) disable iff (rst)
      (mode_wr && mode_code != CODE_BYP && mode_code != CODE_LOCK && st_q != ST_LOCKING)
      |=> st_q == $past(st_q));

endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
   import pll_seq_pkg::*;
#(
   parameter int MULT_W   = 11,
   parameter int DIV_W    = 7,
   parameter int N2_W     = 4,
   parameter int M2_W     = 5,
   parameter int LT_W     = 16,
   parameter int LT_RESET = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  seq_state_t        state,
   input  logic              out_edge,
   output logic [DATA_W-1:0] rd_data,
   output logic              mode_wr,
   output logic [2:0]        mode_code,
   output logic [MULT_W-1:0] mult,
   output logic [DIV_W-1:0]  div,
   output logic [N2_W-1:0]   n2,
   output logic [M2_W-1:0]   m2_act,
   output logic [LT_W-1:0]   lock_time
);

   logic [MULT_W-1:0] mult_q;
   logic [DIV_W-1:0]  div_q;
   logic [N2_W-1:0]   n2_q;
   logic [M2_W-1:0]   m2_pend_q, m2_act_q;
   logic [LT_W-1:0]   lt_q;
   logic              pend_q, ack_q;
   logic              cfg_open, wr_fb, wr_m2, apply;
   logic              unused_wdata;

   assign cfg_open  = (state == ST_BYP);
   assign mode_wr   = wr_en && (addr == A_MODE);
   assign mode_code = wr_data[2:0];
   assign wr_fb     = wr_en && (addr == A_FB) && cfg_open;
   assign wr_m2     = wr_en && (addr == A_POST);
   // running synthesized clock: swap ratio only on a period boundary
   assign apply     = pend_q && ((state != ST_LOCKED) || out_edge);

   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         mult_q    <= MULT_W'(1);
         div_q     <= '0;
         n2_q      <= '0;
         lt_q      <= LT_W'(LT_RESET);
         m2_pend_q <= '0;
         m2_act_q  <= '0;
         pend_q    <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         if (wr_fb) begin
            mult_q <= wr_data[MULT_W-1:0];
            div_q  <= wr_data[FB_DIV_LSB +: DIV_W];
         end
         if (wr_en && addr == A_BYPDIV) n2_q <= wr_data[N2_W-1:0];
         if (wr_en && addr == A_LTIME)  lt_q <= wr_data[LT_W-1:0];
         if (apply) begin
            m2_act_q <= m2_pend_q;
            ack_q    <= ~ack_q;
         end
         if (wr_m2) begin
            m2_pend_q <= wr_data[M2_W-1:0];
            pend_q    <= 1'b1;
         end else if (apply) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (addr)
         A_MODE:   rd_data[2:0] = (state == ST_BYP) ? CODE_BYP : CODE_LOCK;
         A_FB: begin
            rd_data[MULT_W-1:0]         = mult_q;
            rd_data[FB_DIV_LSB +: DIV_W] = div_q;
         end
         A_BYPDIV: rd_data[N2_W-1:0] = n2_q;
         A_POST: begin
            rd_data[M2_W-1:0] = m2_pend_q;
            rd_data[ACK_BIT]  = ack_q;
         end
         A_LTIME:  rd_data[LT_W-1:0] = lt_q;
         A_STAT: begin
            rd_data[0] = (state != ST_LOCKED);
            rd_data[1] = (state == ST_LOCKED);
         end
         default:  rd_data = '0;
      endcase
   end

   assign mult      = mult_q;
   assign div       = div_q;
   assign n2        = n2_q;
   assign m2_act    = m2_act_q;
   assign lock_time = lt_q;

   a_r7_fb_frozen: assert property (@(posedge clk) disable iff (rst)
      (state != ST_BYP) |=> ($stable(mult_q) && $stable(div_q)));

   a_r8_ack_carries_pending: assert property (@(posedge clk) disable iff (rst)
      (ack_q != $past(ack_q)) |-> (m2_act_q == $past(m2_pend_q)));

   a_r8_ack_on_boundary: assert property (@(posedge clk) disable iff (rst)
      (ack_q != $past(ack_q)) |-> ($past(state) != ST_LOCKED || $past(out_edge)));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
   import pll_seq_pkg::*;
#(
   parameter int MULT_W   = 11,
   parameter int DIV_W    = 7,
   parameter int N2_W     = 4,
   parameter int M2_W     = 5,
   parameter int LT_W     = 16,
   parameter int LT_RESET = 16,
   parameter int HOLD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ref_en,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              clk_pulse
);

   if (MULT_W < 1 || MULT_W > FB_DIV_LSB) begin : g_bad_mult
      $error("MULT_W must lie in 1..16");
   end
   if (DIV_W < 1 || DIV_W > DATA_W - FB_DIV_LSB - 1) begin : g_bad_div
      $error("DIV_W must lie in 1..15");
   end
   if (N2_W < 1 || N2_W > 16) begin : g_bad_n2
      $error("N2_W must lie in 1..16");
   end
   if (M2_W < 1 || M2_W > ACK_BIT) begin : g_bad_m2
      $error("M2_W must lie in 1..31");
   end
   if (LT_W < 1 || LT_W > 31) begin : g_bad_lt
      $error("LT_W must lie in 1..31");
   end
   if (HOLD_CYC < 0) begin : g_bad_hold
      $error("HOLD_CYC must not be negative");
   end

   seq_state_t        state;
   logic              src_switch, mode_wr;
   logic [2:0]        mode_code;
   logic [MULT_W-1:0] mult;
   logic [DIV_W-1:0]  div;
   logic [N2_W-1:0]   n2;
   logic [M2_W-1:0]   m2_act;
   logic [LT_W-1:0]   lock_time;
   logic              syn_ev, syn_tick, byp_tick, raw_tick, sel_synth;
   logic              pulse_q;

   pll_seq_regs #(
      .MULT_W(MULT_W), .DIV_W(DIV_W), .N2_W(N2_W),
      .M2_W(M2_W), .LT_W(LT_W), .LT_RESET(LT_RESET)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .state(state), .out_edge(syn_tick), .rd_data(rd_data),
      .mode_wr(mode_wr), .mode_code(mode_code), .mult(mult), .div(div),
      .n2(n2), .m2_act(m2_act), .lock_time(lock_time)
   );

   pll_seq_fsm #(.LT_W(LT_W)) u_fsm (
      .clk(clk), .rst(rst), .ref_en(ref_en), .mode_wr(mode_wr),
      .mode_code(mode_code), .lock_time(lock_time),
      .state(state), .src_switch(src_switch)
   );

   pll_seq_synth #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_synth (
      .clk(clk), .rst(rst), .ref_en(ref_en), .mult(mult), .div(div), .ev(syn_ev)
   );

   pll_seq_div #(.W(M2_W)) u_post_div (
      .clk(clk), .rst(rst), .ev(syn_ev), .ratio(m2_act), .tick(syn_tick)
   );

   pll_seq_div #(.W(N2_W)) u_byp_div (
      .clk(clk), .rst(rst), .ev(ref_en), .ratio(n2), .tick(byp_tick)
   );

   assign sel_synth = (state == ST_LOCKED);
   assign raw_tick  = sel_synth ? syn_tick : byp_tick;

   if (HOLD_CYC > 0) begin : g_hold
      localparam int HW = $clog2(HOLD_CYC + 1);
      logic [HW-1:0] hold_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            hold_q  <= '0;
            pulse_q <= 1'b0;
         end else begin
            if (src_switch)        hold_q <= HW'(HOLD_CYC);
            else if (hold_q != '0) hold_q <= hold_q - 1'b1;
            pulse_q <= raw_tick && !src_switch && (hold_q == '0);
         end
      end

      a_r11_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
         (hold_q != '0) |=> !pulse_q);
   end else begin : g_nohold
      always_ff @(posedge clk) begin
         if (rst) pulse_q <= 1'b0;
         else     pulse_q <= raw_tick && !src_switch;
      end
   end

   assign clk_pulse = pulse_q;

   a_r11_quiet_on_switch: assert property (@(posedge clk) disable iff (rst)
      src_switch |=> !clk_pulse);

   a_r3_status_exclusive: assert property (@(posedge clk) disable iff (rst)
      (addr == A_STAT) |-> $onehot(rd_data[1:0]));

endmodule

// File: tb/pll_seq_ctrl_bench.sv
module pll_seq_ctrl_bench;

   localparam int HOLD = 4;

   typedef struct packed {
      logic        lock;
      logic [3:0]  n2;
      logic [10:0] mult;
      logic [6:0]  dv;
      logic [4:0]  m2;
      logic        pat;
      logic [7:0]  win;
      logic [7:0]  exp;
   } vec_t;

   // R4 rows (lock=0) and R5 rows (lock=1); windows are whole periods
   localparam vec_t VEC [0:8] = '{
      '{1'b0, 4'd0, 11'd1, 7'd0, 5'd0, 1'b0, 8'd20,  8'd20},
      '{1'b0, 4'd2, 11'd1, 7'd0, 5'd0, 1'b0, 8'd30,  8'd10},
      '{1'b0, 4'd1, 11'd1, 7'd0, 5'd0, 1'b1, 8'd40,  8'd10},
      '{1'b0, 4'd4, 11'd1, 7'd0, 5'd0, 1'b0, 8'd50,  8'd10},
      '{1'b1, 4'd0, 11'd1, 7'd0, 5'd3, 1'b0, 8'd40,  8'd10},
      '{1'b1, 4'd0, 11'd2, 7'd4, 5'd0, 1'b0, 8'd50,  8'd20},
      '{1'b1, 4'd0, 11'd2, 7'd4, 5'd1, 1'b0, 8'd100, 8'd20},
      '{1'b1, 4'd0, 11'd3, 7'd1, 5'd4, 1'b0, 8'd50,  8'd10},
      '{1'b1, 4'd0, 11'd1, 7'd0, 5'd1, 1'b1, 8'd40,  8'd10}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ref_en = 1'b1;
   logic        ref_pat = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        clk_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) ref_en <= ref_pat ? ~ref_en : 1'b1;

   pll_seq_ctrl u_pll_seq_ctrl (
      .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .clk_pulse(clk_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic count_pulses(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (clk_pulse) c++;
      end
   endtask

   function automatic logic [31:0] fb_word(input logic [10:0] m, input logic [6:0] n);
      logic [31:0] w;
      w = '0;
      w[10:0] = m;
      w[22:16] = n;
      return w;
   endfunction

   task automatic wait_locked();
      logic [31:0] s;
      for (int i = 0; i < 400; i++) begin
         rd(3'd5, s);
         if (s[1]) break;
         @(negedge clk);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

   initial begin
      logic [31:0] d;
      logic        a0;
      int          c;
      bit          quiet, seen;

      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R1 status", d[1:0], 1);
      rd(3'd0, d); chk(d[2:0] == 3'h4, "R1 mode", d[2:0], 4);
      rd(3'd3, d); chk(d == 32'd0, "R1 post/ack", d, 0);
      rd(3'd4, d); chk(d == 32'd16, "R1 lock time", d, 16);
      rd(3'd1, d); chk(d == 32'd1, "R1 feedback", d, 1);
      rd(3'd2, d); chk(d == 32'd0, "R1 bypass divide", d, 0);

      // table walk: R4 bypass rates, R5 synthesized rates
      wr(3'd4, 32'd8);
      for (int r = 0; r < 9; r++) begin
         wr(3'd0, 32'h4);
         ref_pat = VEC[r].pat;
         repeat (8) @(negedge clk);
         wr(3'd1, fb_word(VEC[r].mult, VEC[r].dv));
         wr(3'd2, 32'(VEC[r].n2));
         wr(3'd3, 32'(VEC[r].m2));
         if (VEC[r].lock) begin
            wr(3'd0, 32'h7);
            wait_locked();
         end
         repeat (HOLD + 24) @(negedge clk);
         count_pulses(int'(VEC[r].win), c);
         chk(c == int'(VEC[r].exp), VEC[r].lock ? "R5 synth rate" : "R4 bypass rate",
             c, int'(VEC[r].exp));
      end

      // R2/R3/R11: exact lock timing and quiet switch into lock
      wr(3'd0, 32'h4);
      ref_pat = 1'b0;
      repeat (8) @(negedge clk);
      wr(3'd1, fb_word(11'd1, 7'd0));
      wr(3'd2, 32'd0);
      wr(3'd3, 32'd0);
      wr(3'd4, 32'd10);
      wr(3'd0, 32'h7);
      repeat (10) @(negedge clk);
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R2 not locked at T, R3 pending reads bypass", d[1:0], 1);
      @(negedge clk);
      rd(3'd5, d); chk(d[1:0] == 2'b10, "R2 locked at T+1, R3", d[1:0], 2);
      quiet = !clk_pulse;
      for (int i = 0; i < HOLD; i++) begin
         @(negedge clk);
         if (clk_pulse) quiet = 1'b0;
      end
      chk(quiet, "R11 quiet entering lock", int'(!quiet), 0);
      @(negedge clk);
      chk(clk_pulse == 1'b1, "R11 output resumes after hold", clk_pulse, 1);

      // R7 feedback write ignored while locked
      wr(3'd1, fb_word(11'd5, 7'd2));
      rd(3'd1, d); chk(d == 32'd1, "R7 feedback frozen in lock", d, 1);

      // R10 invalid code while locked
      wr(3'd0, 32'h5);
      repeat (3) @(negedge clk);
      rd(3'd5, d); chk(d[1:0] == 2'b10, "R10 status kept in lock", d[1:0], 2);
      rd(3'd0, d); chk(d[2:0] == 3'h7, "R10 mode kept in lock", d[2:0], 7);

      // R8 on-the-fly post divide changes, both directions
      rd(3'd3, d); a0 = d[31];
      wr(3'd3, 32'd3);
      seen = 1'b0;
      for (int i = 0; i < 12 && !seen; i++) begin
         rd(3'd3, d);
         if (d[31] != a0) begin
            seen = 1'b1;
            chk(clk_pulse == 1'b1, "R8 ack with pulse (rise/fall 1)", clk_pulse, 1);
         end else begin
            @(negedge clk);
         end
      end
      chk(seen, "R8 ack toggled", int'(seen), 1);
      wr(3'd3, 32'd1);
      seen = 1'b0;
      for (int i = 0; i < 12 && !seen; i++) begin
         rd(3'd3, d);
         if (d[31] == a0) begin
            seen = 1'b1;
            chk(clk_pulse == 1'b1, "R8 ack with pulse (toggle back)", clk_pulse, 1);
         end else begin
            @(negedge clk);
         end
      end
      chk(seen, "R8 ack toggled back", int'(seen), 1);
      count_pulses(20, c);
      chk(c == 10, "R8 new post divide rate", c, 10);

      // R6/R11 return to bypass
      wr(3'd0, 32'h4);
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R6 bypass at once", d[1:0], 1);
      quiet = !clk_pulse;
      for (int i = 0; i < HOLD; i++) begin
         @(negedge clk);
         if (clk_pulse) quiet = 1'b0;
      end
      chk(quiet, "R11 quiet entering bypass", int'(!quiet), 0);
      @(negedge clk);
      chk(clk_pulse == 1'b1, "R11 bypass output resumes", clk_pulse, 1);

      // R9 post divide write while in bypass
      rd(3'd3, d); a0 = d[31];
      wr(3'd3, 32'd7);
      rd(3'd3, d); chk(d[31] == a0, "R9 ack not yet", d[31], a0);
      @(negedge clk);
      rd(3'd3, d); chk(d[31] == ~a0 && d[4:0] == 5'd7, "R9 ack toggled", d[31], ~a0);

      // R10 invalid code in bypass
      wr(3'd0, 32'h2);
      repeat (30) @(negedge clk);
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R10 stays bypass", d[1:0], 1);

      // R2 with zero lock time
      wr(3'd4, 32'd0);
      wr(3'd0, 32'h7);
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R2 T=0 pending", d[1:0], 1);
      @(negedge clk);
      rd(3'd5, d); chk(d[1:0] == 2'b10, "R2 T=0 locked next cycle", d[1:0], 2);

      // R7 while lock pending, then accepted in bypass
      wr(3'd0, 32'h4);
      wr(3'd4, 32'd200);
      wr(3'd0, 32'h7);
      wr(3'd1, fb_word(11'd9, 7'd0));
      rd(3'd1, d); chk(d == 32'd1, "R7 frozen while pending", d, 1);
      wr(3'd0, 32'h4);
      rd(3'd5, d); chk(d[1:0] == 2'b01, "R6 abort pending lock", d[1:0], 1);
      wr(3'd1, fb_word(11'd9, 7'd3));
      rd(3'd1, d); chk(d == fb_word(11'd9, 7'd3), "R7 accepted in bypass", d, fb_word(11'd9, 7'd3));

      report();
   end

endmodule